// File: doc/BRIEF.md
# Line Buffer Host Command Controller

This block is the host-facing controller of a serial line buffer. The host writes 16-bit words over a simple strobe interface. A word written with the command/data select high is a command, and its top four bits carry the opcode. A word written with the select low is line data. The controller holds the configuration registers and sequences the buffer through three modes: static, write and send. In write mode it stores data words into the line memory and can drive a DMA request that releases once the programmed number of words has arrived.

In send mode the controller hands off to a serializer. It starts the serializer with a one-cycle pulse and holds a busy indication until the serializer reports completion. Completion raises an interrupt, and the next bus write withdraws it. A transmit-repeat command resends the stored line. A stop command returns the block to static mode from any state and keeps the configuration.

Top module: `lbuf_host_ctl`

## Requirements
- R1: A write is taken on the rising edge of `wr_ni` while `cs_ni` or `dack_ni` is low. With `cmd_i` high it is a command; with `cmd_i` low it is line data. A rising edge while both selects are high has no effect.
- R2: The opcode is carried in d[15:12]: initialize 1000 (d[5:0] to `init_cfg_o`), word count 0111 (d[8:0]), prefix length 0110 (d[11:0]), output format 0100 (d[1:0]). These four commands are accepted only in static mode.
- R3: After reset the mode is static (0), `dreq_no`, `busy_no` and `intr_no` are high, and every configuration output is 0.
- R4: The operation-mode command has opcode 0000. If d[0]=0 it enters write mode (`mode_o`=1); if d[0]=1 it enters send mode (`mode_o`=2). It is accepted in static mode, in write mode, and in send mode once the transmission is complete.
- R5: In write mode, data words go to `mem_addr_o` 0, 1, 2, … from each entry to write mode, with one `mem_we_o` pulse per word. After 320 words, further data writes produce no pulse.
- R6: If init bit 4 is set, entering write mode drives `dreq_no` low. It returns high once N+1 words are stored, where N is the word-count register, or when memory is full. If init bit 4 is clear, `dreq_no` stays high. `dreq_no` is high in static mode.
- R7: Bit d[3] of the operation-mode command masks the DMA request, and `dreq_no` then stays high in write mode.
- R8: Entering send mode pulls `busy_no` low and pulses `send_start_o` for one cycle. While busy, `send_done_i` raises `busy_no` and pulls `intr_no` low. The next bus write returns `intr_no` high.
- R9: Transmit repeat (0010) is accepted only in send mode with the transmission complete. It pulses `send_start_o` and pulls `busy_no` low again.
- R10: Stop (1111) is accepted in any mode. It returns the block to static mode and sets `busy_no`, `intr_no` and `dreq_no` high. It clears `fixed_line_o` and keeps the init, format, word-count and prefix-length registers.
- R11: One-line fixed data (0011, count in d[8:0]) is accepted only in write mode. It sets `fixed_line_o`, and `fixed_bits_o` = (prefix+1 if init bit 3 is set, else 0) + (count+1)×16.
- R12: Data writes outside write mode, undefined opcodes and commands that are illegal in the current mode leave every register and output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| d_i | input | 16 | Bus data word |
| cmd_i | input | 1 | High: command, low: data |
| cs_ni | input | 1 | Chip select, active low |
| dack_ni | input | 1 | DMA acknowledge, active low |
| wr_ni | input | 1 | Write strobe, captured on rising edge |
| send_done_i | input | 1 | Serializer finished the line |
| dreq_no | output | 1 | DMA request, active low |
| busy_no | output | 1 | Sending, active low |
| intr_no | output | 1 | Interrupt, active low |
| mode_o | output | 2 | 0 static, 1 write, 2 send |
| mem_we_o | output | 1 | Line memory write enable |
| mem_addr_o | output | 9 | Line memory word address |
| mem_data_o | output | 16 | Line memory write data |
| send_start_o | output | 1 | Start pulse to serializer |
| init_cfg_o | output | 6 | Initialization register |
| fmt_o | output | 2 | Output format register |
| prefix_len_o | output | 12 | Fixed prefix length register |
| word_cnt_o | output | 9 | DMA word count register |
| fixed_line_o | output | 1 | One-line fixed data selected |
| fixed_bits_o | output | 14 | Fixed-level bit count for send |

## Verification
A wrong mode register shows on `mode_o` two cycles after the offending strobe, and it also shows as mis-gated memory pulses or request changes on the following writes. An address counter that does not restart or does not saturate shows on `mem_addr_o` at the next accepted word. A word count that is off by one shows as `dreq_no` rising one word early or late. Configuration that a stop or an illegal command disturbs shows at once on the register outputs.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_WRITE  = 2'd1,
    MODE_SEND   = 2'd2
  } mode_e;

  typedef enum logic [3:0] {
    OP_INIT  = 4'b1000,
    OP_WCNT  = 4'b0111,
    OP_PFX   = 4'b0110,
    OP_FMT   = 4'b0100,
    OP_MODE  = 4'b0000,
    OP_FLINE = 4'b0011,
    OP_RPT   = 4'b0010,
    OP_STOP  = 4'b1111
  } op_e;

  typedef struct packed {
    logic ld_init;
    logic ld_wcnt;
    logic ld_pfx;
    logic ld_fmt;
    logic go_write;
    logic go_send;
    logic ld_fline;
    logic rpt;
    logic stop;
  } act_t;
endpackage

// File: rtl/lbuf_bus_if.sv
module lbuf_bus_if #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ni,
  input  logic          cs_ni,
  input  logic          dack_ni,
  input  logic          cmd_i,
  input  logic [DW-1:0] d_i,
  output logic          stb_o,
  output logic          is_cmd_o,
  output logic [DW-1:0] dat_o
);
  logic wr_q;
  logic rise;

  assign rise = !wr_q && wr_ni && (!cs_ni || !dack_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q     <= 1'b1;
      stb_o    <= 1'b0;
      is_cmd_o <= 1'b0;
      dat_o    <= '0;
    end else begin
      wr_q  <= wr_ni;
      stb_o <= rise;
      if (rise) begin
        is_cmd_o <= cmd_i;
        dat_o    <= d_i;
      end
    end
  end

  assert_single_stb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
endmodule

// File: rtl/lbuf_cmd_dec.sv
module lbuf_cmd_dec
  import lbuf_pkg::*;
(
  input  logic        stb_i,
  input  logic        is_cmd_i,
  input  logic [3:0]  op_i,
  input  logic        sel_i,
  input  mode_e       mode_i,
  input  logic        busy_ni,
  output act_t        act_o
);
  always_comb begin
    act_o = '0;
    if (stb_i && is_cmd_i) begin
      case (op_i)
        OP_INIT:  act_o.ld_init = (mode_i == MODE_STATIC);
        OP_WCNT:  act_o.ld_wcnt = (mode_i == MODE_STATIC);
        OP_PFX:   act_o.ld_pfx  = (mode_i == MODE_STATIC);
        OP_FMT:   act_o.ld_fmt  = (mode_i == MODE_STATIC);
        OP_MODE: begin
          if (mode_i != MODE_SEND || busy_ni) begin
            act_o.go_write = !sel_i;
            act_o.go_send  = sel_i;
          end
        end
        OP_FLINE: act_o.ld_fline = (mode_i == MODE_WRITE);
        OP_RPT:   act_o.rpt      = (mode_i == MODE_SEND) && busy_ni;
        OP_STOP:  act_o.stop     = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/lbuf_dma_seq.sv
module lbuf_dma_seq #(
  parameter int DEPTH = 320,
  parameter int AW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          start_i,
  input  logic          req_en_i,
  input  logic [AW-1:0] wcnt_i,
  input  logic          word_i,
  output logic [AW-1:0] addr_o,
  output logic          full_o,
  output logic          dreq_no
);
  logic [AW-1:0] addr_q;
  logic          dreq_nq;

  assign full_o  = (addr_q == AW'(DEPTH));
  assign addr_o  = addr_q;
  assign dreq_no = dreq_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      dreq_nq <= 1'b1;
    end else if (clr_i) begin
      addr_q  <= '0;
      dreq_nq <= 1'b1;
    end else if (start_i) begin
      addr_q  <= '0;
      dreq_nq <= !req_en_i;
    end else if (word_i && !full_o) begin
      addr_q <= addr_q + AW'(1);
      // release after N+1 words or on last slot
      if (!dreq_nq && (addr_q >= wcnt_i || addr_q == AW'(DEPTH - 1)))
        dreq_nq <= 1'b1;
    end
  end

  assert_addr_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= AW'(DEPTH));
  assert_dreq_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> dreq_nq);
endmodule

// File: rtl/lbuf_host_ctl.sv
module lbuf_host_ctl
  import lbuf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 320,
  parameter int PW    = 12,
  parameter int IW    = 6,
  parameter int AW    = $clog2(DEPTH + 1),
  parameter int FBW   = $clog2((1 << PW) + (1 << AW) * 16 + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  d_i,
  input  logic           cmd_i,
  input  logic           cs_ni,
  input  logic           dack_ni,
  input  logic           wr_ni,
  input  logic           send_done_i,
  output logic           dreq_no,
  output logic           busy_no,
  output logic           intr_no,
  output logic [1:0]     mode_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_data_o,
  output logic           send_start_o,
  output logic [IW-1:0]  init_cfg_o,
  output logic [1:0]     fmt_o,
  output logic [PW-1:0]  prefix_len_o,
  output logic [AW-1:0]  word_cnt_o,
  output logic           fixed_line_o,
  output logic [FBW-1:0] fixed_bits_o
);
  localparam int BIT_PFX_EN = 3;
  localparam int BIT_REQ_EN = 4;
  localparam int BIT_MASK   = 3;

  logic          stb, is_cmd;
  logic [DW-1:0] dat;
  act_t          act;
  mode_e         mode_q;
  logic [IW-1:0] init_q;
  logic [AW-1:0] wcnt_q, fcnt_q, addr;
  logic [PW-1:0] pfx_q;
  logic [1:0]    fmt_q;
  logic          fline_q, busy_nq, intr_nq, start_q, we_q, full;
  logic [AW-1:0] maddr_q;
  logic [DW-1:0] mdat_q;
  logic          word_ok;
  logic [FBW-1:0] pfx_part, line_part;

  lbuf_bus_if #(.DW(DW)) i_bus (
    .clk_i, .rst_ni, .wr_ni, .cs_ni, .dack_ni, .cmd_i, .d_i,
    .stb_o(stb), .is_cmd_o(is_cmd), .dat_o(dat)
  );

  lbuf_cmd_dec i_dec (
    .stb_i(stb), .is_cmd_i(is_cmd), .op_i(dat[DW-1 -: 4]), .sel_i(dat[0]),
    .mode_i(mode_q), .busy_ni(busy_nq), .act_o(act)
  );

  assign word_ok = stb && !is_cmd && (mode_q == MODE_WRITE) && !full;

  lbuf_dma_seq #(.DEPTH(DEPTH), .AW(AW)) i_dma (
    .clk_i, .rst_ni,
    .clr_i(act.stop || act.go_send),
    .start_i(act.go_write),
    .req_en_i(init_q[BIT_REQ_EN] && !dat[BIT_MASK]),
    .wcnt_i(wcnt_q),
    .word_i(word_ok),
    .addr_o(addr), .full_o(full), .dreq_no(dreq_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_STATIC;
      init_q  <= '0;
      wcnt_q  <= '0;
      pfx_q   <= '0;
      fmt_q   <= '0;
      fline_q <= 1'b0;
      fcnt_q  <= '0;
      busy_nq <= 1'b1;
      intr_nq <= 1'b1;
      start_q <= 1'b0;
      we_q    <= 1'b0;
      maddr_q <= '0;
      mdat_q  <= '0;
    end else begin
      we_q    <= word_ok;
      start_q <= act.go_send || act.rpt;
      if (word_ok) begin
        maddr_q <= addr;
        mdat_q  <= dat;
      end
      if (stb) intr_nq <= 1'b1;
      if (act.stop) begin
        mode_q  <= MODE_STATIC;
        busy_nq <= 1'b1;
        intr_nq <= 1'b1;
        fline_q <= 1'b0;
      end else begin
        if (act.ld_init) init_q <= dat[IW-1:0];
        if (act.ld_wcnt) wcnt_q <= dat[AW-1:0];
        if (act.ld_pfx)  pfx_q  <= dat[PW-1:0];
        if (act.ld_fmt)  fmt_q  <= dat[1:0];
        if (act.go_write) begin
          mode_q  <= MODE_WRITE;
          fline_q <= 1'b0;
        end
        if (act.go_send) begin
          mode_q  <= MODE_SEND;
          busy_nq <= 1'b0;
        end
        if (act.rpt) busy_nq <= 1'b0;
        if (act.ld_fline) begin
          fline_q <= 1'b1;
          fcnt_q  <= dat[AW-1:0];
        end
        if (send_done_i && !busy_nq && mode_q == MODE_SEND) begin
          busy_nq <= 1'b1;
          intr_nq <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    pfx_part  = init_q[BIT_PFX_EN] ? FBW'(pfx_q) + FBW'(1) : '0;
    line_part = (FBW'(fcnt_q) + FBW'(1)) << 4;
  end

  assign busy_no      = busy_nq;
  assign intr_no      = intr_nq;
  assign mode_o       = mode_q;
  assign mem_we_o     = we_q;
  assign mem_addr_o   = maddr_q;
  assign mem_data_o   = mdat_q;
  assign send_start_o = start_q;
  assign init_cfg_o   = init_q;
  assign fmt_o        = fmt_q;
  assign prefix_len_o = pfx_q;
  assign word_cnt_o   = wcnt_q;
  assign fixed_line_o = fline_q;
  assign fixed_bits_o = pfx_part + line_part;

  assert_we_in_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> mode_q == MODE_WRITE);
  assert_busy_in_send_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_nq |-> mode_q == MODE_SEND);
  assert_start_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> !busy_nq);
  assert_static_dreq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_STATIC |-> dreq_no);
  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != MODE_STATIC |=> $stable(init_q) && $stable(pfx_q) && $stable(wcnt_q) && $stable(fmt_q));
endmodule

// File: tb/test_lbuf_host_ctl.sv
module test_lbuf_host_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] d = '0;
  logic        cmd = 1'b0, cs_n = 1'b1, dack_n = 1'b1, wr_n = 1'b1, done = 1'b0;
  logic        dreq_n, busy_n, intr_n, mem_we, send_start, fixed_line;
  logic [1:0]  mode, fmt;
  logic [8:0]  mem_addr, word_cnt;
  logic [15:0] mem_data;
  logic [5:0]  init_cfg;
  logic [11:0] prefix_len;
  logic [13:0] fixed_bits;

  int n_chk = 0, n_bad = 0, we_cnt = 0, st_cnt = 0;
  logic [8:0]  last_addr = '0;
  logic [15:0] last_data = '0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  lbuf_host_ctl i_lbuf_host_ctl (
    .clk_i(clk), .rst_ni(rst_n), .d_i(d), .cmd_i(cmd), .cs_ni(cs_n), .dack_ni(dack_n),
    .wr_ni(wr_n), .send_done_i(done), .dreq_no(dreq_n), .busy_no(busy_n), .intr_no(intr_n),
    .mode_o(mode), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .send_start_o(send_start), .init_cfg_o(init_cfg), .fmt_o(fmt), .prefix_len_o(prefix_len),
    .word_cnt_o(word_cnt), .fixed_line_o(fixed_line), .fixed_bits_o(fixed_bits)
  );

  always @(negedge clk) begin
    if (mem_we) begin
      we_cnt++;
      last_addr = mem_addr;
      last_data = mem_data;
    end
    if (send_start) st_cnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // sel: 0 chip select, 1 dma acknowledge, 2 neither
  task automatic bus_wr(input logic c, input logic [15:0] v, input int sel);
    @(negedge clk);
    cmd = c; d = v;
    if (sel == 0) cs_n = 1'b0;
    if (sel == 1) dack_n = 1'b0;
    wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; dack_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cmdw(input logic [3:0] op, input logic [11:0] arg);
    bus_wr(1'b1, {op, arg}, 0);
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    chk("R3 mode", mode, 0);
    chk("R3 dreq", dreq_n, 1);
    chk("R3 busy", busy_n, 1);
    chk("R3 intr", intr_n, 1);
    chk("R3 init", init_cfg, 0);
    chk("R3 prefix", prefix_len, 0);
    chk("R3 fixed_bits", fixed_bits, 16);

    // R12 data in static mode ignored
    bus_wr(1'b0, 16'h1234, 0);
    chk("R12 static data", we_cnt, 0);
    // R1 no select: ignored
    bus_wr(1'b1, 16'h8018, 2);
    chk("R1 no select", init_cfg, 0);

    // R2 configuration in static mode
    cmdw(4'b1000, 12'h018);
    chk("R2 init", init_cfg, 6'h18);
    cmdw(4'b0111, 12'd4);
    chk("R2 wcnt", word_cnt, 4);
    cmdw(4'b0110, 12'd5);
    chk("R2 prefix", prefix_len, 5);
    cmdw(4'b0100, 12'd3);
    chk("R2 fmt", fmt, 3);
    // R12 undefined opcode
    cmdw(4'b0001, 12'hFFF);
    chk("R12 undef init", init_cfg, 6'h18);
    chk("R12 undef mode", mode, 0);
    // R9 repeat in static ignored
    cmdw(4'b0010, 12'd0);
    chk("R9 rpt static", st_cnt, 0);
    chk("R9 rpt static busy", busy_n, 1);

    // R4 R6 enter write
    cmdw(4'b0000, 12'd0);
    chk("R4 write mode", mode, 1);
    chk("R6 dreq low", dreq_n, 0);
    cmdw(4'b0110, 12'd9);
    chk("R2 pfx in write", prefix_len, 5);

    // R5 R6 five words via DMA acknowledge, release after N+1=5
    for (int i = 0; i < 5; i++) begin
      chk("R6 dreq before word", dreq_n, 0);
      bus_wr(1'b0, 16'hA000 + 16'(i), 1);
      chk("R5 addr", last_addr, i);
      chk("R5 data", last_data, 16'hA000 + i);
    end
    chk("R6 dreq released", dreq_n, 1);
    chk("R5 word count", we_cnt, 5);

    // R11 fixed line with prefix
    cmdw(4'b0011, 12'd2);
    chk("R11 fixed flag", fixed_line, 1);
    chk("R11 fixed bits", fixed_bits, 6 + 3 * 16);

    // R8 send
    cmdw(4'b0000, 12'd1);
    chk("R4 send mode", mode, 2);
    chk("R8 busy", busy_n, 0);
    chk("R8 start", st_cnt, 1);
    cmdw(4'b0011, 12'd7);
    chk("R11 fline in send", fixed_bits, 54);
    cmdw(4'b0000, 12'd0);
    chk("R4 mode cmd while busy", mode, 2);
    cmdw(4'b0010, 12'd0);
    chk("R9 rpt while busy", st_cnt, 1);
    pulse_done();
    chk("R8 busy done", busy_n, 1);
    chk("R8 intr", intr_n, 0);
    cmdw(4'b0010, 12'd0);
    chk("R9 rpt start", st_cnt, 2);
    chk("R9 rpt busy", busy_n, 0);
    chk("R8 intr cleared", intr_n, 1);
    pulse_done();

    // R10 stop keeps config
    cmdw(4'b1111, 12'd0);
    chk("R10 mode", mode, 0);
    chk("R10 busy", busy_n, 1);
    chk("R10 intr", intr_n, 1);
    chk("R10 fline", fixed_line, 0);
    chk("R10 init", init_cfg, 6'h18);
    chk("R10 prefix", prefix_len, 5);
    chk("R10 wcnt", word_cnt, 4);
    chk("R10 fmt", fmt, 3);

    // R7 mask
    cmdw(4'b0000, 12'h008);
    chk("R7 mode", mode, 1);
    chk("R7 dreq masked", dreq_n, 1);
    cmdw(4'b1111, 12'd0);

    // R6 sweep of word count
    for (int n = 0; n < 8; n++) begin
      cmdw(4'b0111, 12'(n));
      cmdw(4'b0000, 12'd0);
      for (int k = 0; k <= n; k++) begin
        chk("R6 sweep low", dreq_n, 0);
        bus_wr(1'b0, 16'(k), 0);
        chk("R5 sweep addr", last_addr, k);
      end
      chk("R6 sweep release", dreq_n, 1);
      cmdw(4'b1111, 12'd0);
      chk("R10 sweep stop dreq", dreq_n, 1);
    end

    // R6 request disabled, R5 saturation
    cmdw(4'b1000, 12'h000);
    cmdw(4'b0000, 12'd0);
    chk("R6 disabled", dreq_n, 1);
    base = we_cnt;
    for (int i = 0; i < 322; i++) begin
      bus_wr(1'b0, 16'(i ^ 16'h5A5A), 0);
      if (i < 320) begin
        chk("R5 sat addr", last_addr, i);
        chk("R5 sat data", last_data, i ^ 16'h5A5A);
      end
    end
    chk("R5 saturated count", we_cnt - base, 320);
    chk("R5 last addr", last_addr, 319);

    // R11 without prefix
    cmdw(4'b0011, 12'd0);
    chk("R11 no prefix", fixed_bits, 16);
    cmdw(4'b1111, 12'd0);
    chk("R10 stop write", mode, 0);
    base = we_cnt;
    bus_wr(1'b0, 16'hBEEF, 1);
    chk("R12 data after stop", we_cnt - base, 0);

    finish_run();
  end
endmodule